// File: doc/BRIEF.md
# SPI Host Interrupt Status and Mask Registers

This block is the interrupt logic of a SPI host controller. It sits next to the transmit and receive FIFOs and the shift engine. It watches the fill level of each FIFO and two single-cycle error pulses, and records what it sees in a status register. It combines that register with a mask to drive one interrupt line towards the processor.

Software reaches the block through a small register bus with a write strobe, a read strobe, an 8-bit address and 32-bit data. Read data is combinational and valid in the same cycle as the read strobe. Mask bits are never written directly. One write-only port sets mask bits and a second write-only port clears them, so concurrent software agents can change their own sources without a read-modify-write. Two status sources compare a FIFO level against a programmable threshold, which lets a driver decide how empty the TX FIFO or how full the RX FIFO must be before it is woken.

Top module: `spi_irq_regs`

## Requirements
- R1: After synchronous reset, status and mask read 0, the TX threshold reads 1, the RX threshold reads 32 and `irq` is low.
- R2: Register addresses are: status 0x04, mask-set port 0x08, mask-clear port 0x0C, mask 0x10, TX threshold 0x28, RX threshold 0x2C. A read of either mask port, or of any other address, returns 0.
- R3: Status and mask share one layout: bit 0 RX overrun, bit 2 TX below threshold, bit 3 TX full, bit 4 RX at or above threshold, bit 5 RX full, bit 6 TX starved. Bit 1 and bits 31:7 always read 0.
- R4: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: An RX overrun pulse sets bit 0 and a TX starve pulse sets bit 6. Each bit stays set until it is cleared. A pulse in the same cycle as a clear of its bit leaves the bit set.
- R6: Bit 2 is set in the cycle after the TX fill level is below the TX threshold. A threshold of 1 therefore signals an empty FIFO.
- R7: Bit 4 is set in the cycle after the RX fill level is at or above the RX threshold.
- R8: Bit 3 is set when the TX fill equals FIFO_DEPTH. Bit 5 is set when the RX fill equals FIFO_DEPTH.
- R9: A level bit that is cleared while its condition still holds reads set again in the next cycle. If the condition has gone away, the bit stays clear.
- R10: A 1 written to the mask-set port sets that mask bit, and a 1 written to the mask-clear port clears it. Zeros written to either port change nothing. Bits outside the layout of R3 never become set.
- R11: `irq` is high exactly when some status bit and its mask bit are both 1.
- R12: The two thresholds are writable, they read back their low LEVEL_W bits, and a new threshold takes effect in the level comparison from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, 0 otherwise |
| tx_fill | input | LEVEL_W | Current TX FIFO entry count |
| rx_fill | input | LEVEL_W | Current RX FIFO entry count |
| rx_overrun_pulse | input | 1 | One-cycle RX overrun event |
| tx_starve_pulse | input | 1 | One-cycle TX underflow event |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default build: FIFO_DEPTH 63, which gives a 6-bit fill width, with reset thresholds 1 and 32. With a depth this small, both full comparisons can be reached by driving a fill of 63. Moving the thresholds to 12 and 40 lets the bench show that a threshold change alone, with the fill level held, makes a level bit appear or stay away. The same stimulus, with the fill levels unchanged, also covers the cleared-but-still-true case of a level bit and the case where a bit is cleared and its condition has gone.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NBITS  = 7;

    // register addresses
    localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] A_ENA  = 8'h08;
    localparam logic [ADDR_W-1:0] A_DIS  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MASK = 8'h10;
    localparam logic [ADDR_W-1:0] A_TXWM = 8'h28;
    localparam logic [ADDR_W-1:0] A_RXWM = 8'h2C;

    // bit positions shared by status and mask
    localparam int B_RX_OVR    = 0;
    localparam int B_TX_LOW    = 2;
    localparam int B_TX_FULL   = 3;
    localparam int B_RX_AVAIL  = 4;
    localparam int B_RX_FULL   = 5;
    localparam int B_TX_STARVE = 6;

    localparam logic [NBITS-1:0] IMPL_BITS = 7'b1111101;

    typedef logic [NBITS-1:0] irq_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_ENA,
        SEL_DIS,
        SEL_MASK,
        SEL_TXWM,
        SEL_RXWM
    } reg_sel_e;

    typedef struct packed {
        logic stat_clr;
        logic mask_set;
        logic mask_clr;
        logic txwm_ld;
        logic rxwm_ld;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_STAT:  s = SEL_STAT;
            A_ENA:   s = SEL_ENA;
            A_DIS:   s = SEL_DIS;
            A_MASK:  s = SEL_MASK;
            A_TXWM:  s = SEL_TXWM;
            A_RXWM:  s = SEL_RXWM;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic irq_vec_t keep_impl(input irq_vec_t v);
        return v & IMPL_BITS;
    endfunction

endpackage

// File: rtl/spi_irq_bus.sv
module spi_irq_bus
    import spi_irq_pkg::*;
#(
    parameter int LEVEL_W = 6
) (
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  irq_vec_t            stat,
    input  irq_vec_t            mask,
    input  logic [LEVEL_W-1:0]  tx_wm,
    input  logic [LEVEL_W-1:0]  rx_wm,
    output wr_strobe_t          strobe,
    output irq_vec_t            wvec,
    output logic [LEVEL_W-1:0]  wlvl,
    output logic [DATA_W-1:0]   bus_rdata
);

    reg_sel_e sel;
    logic     unused_wdata;

    assign sel          = decode_addr(bus_addr);
    assign wvec         = bus_wdata[NBITS-1:0];
    assign wlvl         = bus_wdata[LEVEL_W-1:0];
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        strobe          = '0;
        strobe.stat_clr = bus_wr && (sel == SEL_STAT);
        strobe.mask_set = bus_wr && (sel == SEL_ENA);
        strobe.mask_clr = bus_wr && (sel == SEL_DIS);
        strobe.txwm_ld  = bus_wr && (sel == SEL_TXWM);
        strobe.rxwm_ld  = bus_wr && (sel == SEL_RXWM);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_STAT: bus_rdata[NBITS-1:0]   = stat;
                SEL_MASK: bus_rdata[NBITS-1:0]   = mask;
                SEL_TXWM: bus_rdata[LEVEL_W-1:0] = tx_wm;
                SEL_RXWM: bus_rdata[LEVEL_W-1:0] = rx_wm;
                default:  bus_rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_events.sv
module spi_irq_events
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int LEVEL_W    = 6
) (
    input  logic [LEVEL_W-1:0] tx_fill,
    input  logic [LEVEL_W-1:0] rx_fill,
    input  logic [LEVEL_W-1:0] tx_wm,
    input  logic [LEVEL_W-1:0] rx_wm,
    input  logic               rx_overrun_pulse,
    input  logic               tx_starve_pulse,
    output irq_vec_t           set_vec
);

    localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(FIFO_DEPTH);

    always_comb begin
        set_vec              = '0;
        set_vec[B_RX_OVR]    = rx_overrun_pulse;
        set_vec[B_TX_LOW]    = (tx_fill < tx_wm);
        set_vec[B_TX_FULL]   = (tx_fill == FULL_LVL);
        set_vec[B_RX_AVAIL]  = (rx_fill >= rx_wm);
        set_vec[B_RX_FULL]   = (rx_fill == FULL_LVL);
        set_vec[B_TX_STARVE] = tx_starve_pulse;
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_vec,
    input  logic     clr_en,
    input  irq_vec_t clr_vec,
    output irq_vec_t stat
);

    logic unused_in;
    assign unused_in = ^(set_vec & ~IMPL_BITS) ^ ^(clr_vec & ~IMPL_BITS);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_impl
            logic bit_q;
            // a set in the same cycle as a clear wins
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= (bit_q & ~(clr_en & clr_vec[i])) | set_vec[i];
                end
            end
            assign stat[i] = bit_q;
        end else begin : g_none
            assign stat[i] = 1'b0;
        end
    end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_en,
    input  logic     clr_en,
    input  irq_vec_t wvec,
    output irq_vec_t mask
);

    irq_vec_t set_bits;
    irq_vec_t clr_bits;
    logic     unused_in;

    assign set_bits  = set_en ? keep_impl(wvec) : '0;
    assign clr_bits  = clr_en ? wvec : '0;
    assign unused_in = ^(wvec & ~IMPL_BITS);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= (bit_q | set_bits[i]) & ~clr_bits[i];
                end
            end
            assign mask[i] = bit_q;
        end else begin : g_none
            assign mask[i] = 1'b0;
        end
    end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int TX_WM_RST  = 1,
    parameter int RX_WM_RST  = 32,
    parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [LEVEL_W-1:0] tx_fill,
    input  logic [LEVEL_W-1:0] rx_fill,
    input  logic               rx_overrun_pulse,
    input  logic               tx_starve_pulse,
    output logic               irq
);

    wr_strobe_t         strobe;
    irq_vec_t           wvec;
    logic [LEVEL_W-1:0] wlvl;
    irq_vec_t           set_vec;
    irq_vec_t           stat_q;
    irq_vec_t           mask_q;
    logic [LEVEL_W-1:0] tx_wm_q;
    logic [LEVEL_W-1:0] rx_wm_q;

    spi_irq_bus #(.LEVEL_W(LEVEL_W)) u_bus (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat      (stat_q),
        .mask      (mask_q),
        .tx_wm     (tx_wm_q),
        .rx_wm     (rx_wm_q),
        .strobe    (strobe),
        .wvec      (wvec),
        .wlvl      (wlvl),
        .bus_rdata (bus_rdata)
    );

    spi_irq_events #(.FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W)) u_events (
        .tx_fill          (tx_fill),
        .rx_fill          (rx_fill),
        .tx_wm            (tx_wm_q),
        .rx_wm            (rx_wm_q),
        .rx_overrun_pulse (rx_overrun_pulse),
        .tx_starve_pulse  (tx_starve_pulse),
        .set_vec          (set_vec)
    );

    spi_irq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_en  (strobe.stat_clr),
        .clr_vec (wvec),
        .stat    (stat_q)
    );

    spi_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (strobe.mask_set),
        .clr_en (strobe.mask_clr),
        .wvec   (wvec),
        .mask   (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wm_q <= LEVEL_W'(TX_WM_RST);
            rx_wm_q <= LEVEL_W'(RX_WM_RST);
        end else begin
            if (strobe.txwm_ld) tx_wm_q <= wlvl;
            if (strobe.rxwm_ld) rx_wm_q <= wlvl;
        end
    end

    assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
    import spi_irq_pkg::*;
#(
    parameter int LEVEL_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [LEVEL_W-1:0] tx_fill,
    input logic               rx_overrun_pulse,
    input logic               tx_starve_pulse,
    input logic               irq,
    input irq_vec_t           stat_q,
    input irq_vec_t           mask_q,
    input logic [LEVEL_W-1:0] tx_wm_q
);

    p_ovr_sets_r5: assert property (@(posedge clk) disable iff (rst)
        rx_overrun_pulse |=> stat_q[B_RX_OVR]);

    p_starve_sets_r5: assert property (@(posedge clk) disable iff (rst)
        tx_starve_pulse |=> stat_q[B_TX_STARVE]);

    p_ovr_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_q[B_RX_OVR] && !(bus_wr && bus_addr == A_STAT && bus_wdata[B_RX_OVR]))
        |=> stat_q[B_RX_OVR]);

    p_tx_low_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_fill < tx_wm_q) |=> stat_q[B_TX_LOW]);

    p_mask_set_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ENA) |=>
        ((mask_q & $past(bus_wdata[NBITS-1:0]) & IMPL_BITS) ==
         ($past(bus_wdata[NBITS-1:0]) & IMPL_BITS)));

    p_mask_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DIS) |=>
        ((mask_q & $past(bus_wdata[NBITS-1:0])) == '0));

    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (!$stable(stat_q) || !$stable(mask_q)));

endmodule

bind spi_irq_regs spi_irq_regs_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .tx_fill          (tx_fill),
    .rx_overrun_pulse (rx_overrun_pulse),
    .tx_starve_pulse  (tx_starve_pulse),
    .irq              (irq),
    .stat_q           (stat_q),
    .mask_q           (mask_q),
    .tx_wm_q          (tx_wm_q)
);

// File: tb/spi_irq_regs_test.sv
`timescale 1ns/100ps
module spi_irq_regs_test;

    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [LW-1:0] tx_fill = 6'd10;
    logic [LW-1:0] rx_fill = 6'd0;
    logic          rx_overrun_pulse = 1'b0;
    logic          tx_starve_pulse = 1'b0;
    logic          irq;
    logic          irq_probe = 1'b0;
    bit            done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       req;
        bit          is_irq;
    } item_t;

    item_t sbq[$];

    always #2.5 clk = ~clk;

    spi_irq_regs uut (
        .clk              (clk),
        .rst              (rst),
        .bus_wr           (bus_wr),
        .bus_rd           (bus_rd),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .tx_fill          (tx_fill),
        .rx_fill          (rx_fill),
        .rx_overrun_pulse (rx_overrun_pulse),
        .tx_starve_pulse  (tx_starve_pulse),
        .irq              (irq)
    );

    // monitor: compares at the falling edge, inputs move after the rising edge
    always @(negedge clk) begin
        if (bus_rd || irq_probe) begin
            item_t it;
            logic [31:0] act;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: actual=sample expected=queued item");
            end else begin
                it  = sbq.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        it.exp = e; it.req = r; it.is_irq = 1'b0;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        item_t it;
        it.exp = {31'b0, e}; it.req = r; it.is_irq = 1'b1;
        sbq.push_back(it);
        irq_probe = 1'b1;
        step();
        irq_probe = 1'b0;
    endtask

    task automatic pulse(input logic ovr, input logic stv);
        rx_overrun_pulse = ovr; tx_starve_pulse = stv;
        step();
        rx_overrun_pulse = 1'b0; tx_starve_pulse = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset values
        rd(8'h04, 32'h0, "R1");
        rd(8'h10, 32'h0, "R1");
        rd(8'h28, 32'd1, "R1");
        rd(8'h2C, 32'd32, "R1");
        chk_irq(1'b0, "R1");
        // R5 R3 sticky events
        pulse(1'b1, 1'b0);
        rd(8'h04, 32'h01, "R5");
        pulse(1'b0, 1'b1);
        step(); step();
        rd(8'h04, 32'h41, "R3");
        // R4 write one to clear, zero ignored
        wr(8'h04, 32'h01);
        rd(8'h04, 32'h40, "R4");
        wr(8'h04, 32'h00);
        rd(8'h04, 32'h40, "R4");
        wr(8'h04, 32'h40);
        rd(8'h04, 32'h00, "R4");
        // R5 set wins over clear in the same cycle
        tx_starve_pulse = 1'b1;
        wr(8'h04, 32'h40);
        tx_starve_pulse = 1'b0;
        rd(8'h04, 32'h40, "R5");
        wr(8'h04, 32'h40);
        // R6 TX empty with threshold 1, R9 re-set while true
        tx_fill = 6'd0;
        step();
        rd(8'h04, 32'h04, "R6");
        wr(8'h04, 32'h04);
        rd(8'h04, 32'h04, "R9");
        tx_fill = 6'd10;
        wr(8'h04, 32'h04);
        rd(8'h04, 32'h00, "R9");
        // R12 TX threshold moves the comparison
        wr(8'h28, 32'd12);
        rd(8'h28, 32'd12, "R12");
        step();
        rd(8'h04, 32'h04, "R12");
        wr(8'h28, 32'd1);
        wr(8'h04, 32'h04);
        rd(8'h04, 32'h00, "R6");
        // R7 RX threshold, R12 raised threshold suppresses it
        rx_fill = 6'd32;
        step();
        rd(8'h04, 32'h10, "R7");
        wr(8'h2C, 32'd40);
        wr(8'h04, 32'h10);
        rd(8'h04, 32'h00, "R12");
        rd(8'h2C, 32'd40, "R12");
        // R8 full flags
        tx_fill = 6'd63;
        step();
        rd(8'h04, 32'h08, "R8");
        rx_fill = 6'd63;
        step();
        rd(8'h04, 32'h38, "R8");
        tx_fill = 6'd10; rx_fill = 6'd0;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h00, "R4");
        // R10 mask set and clear ports
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h10, 32'h7D, "R10");
        rd(8'h08, 32'h0, "R2");
        rd(8'h0C, 32'h0, "R2");
        rd(8'h00, 32'h0, "R2");
        wr(8'h0C, 32'h05);
        rd(8'h10, 32'h78, "R10");
        wr(8'h0C, 32'h00);
        wr(8'h08, 32'h00);
        rd(8'h10, 32'h78, "R10");
        // R11 interrupt output
        chk_irq(1'b0, "R11");
        pulse(1'b1, 1'b0);
        chk_irq(1'b0, "R11");
        pulse(1'b0, 1'b1);
        chk_irq(1'b1, "R11");
        wr(8'h0C, 32'h40);
        chk_irq(1'b0, "R11");
        wr(8'h08, 32'h01);
        chk_irq(1'b1, "R11");
        wr(8'h04, 32'h41);
        chk_irq(1'b0, "R11");
        rd(8'h04, 32'h00, "R4");
        step(); step();
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual=%0d left expected=0 left", sbq.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule